// File: doc/BRIEF.md
# Two-Dimensional Strided DMA Address Generator

This block produces the word-address stream for a single channel of a DMA engine that moves rectangular regions. A transfer consists of one or more rows. Each row is a run of consecutive 32-bit words. The start of each row lies a programmable stride beyond the start of the previous row, so a gap may separate the rows. All addresses are word addresses, meaning a byte address shifted right by two.

Software first sets the row length, the row count, the stride, the direction bit and the burst bit. It then writes the start address, and that write launches the walk. The block presents one request per transfer unit and waits for the ready handshake. In single mode a unit is one word. In burst mode a unit is up to four words. A one-cycle done pulse follows the final handshake. The current-address output can be read at any time and points at the next word still to move. Software can therefore compute the remaining byte count from it. A stop input abandons the walk at once.

Top module: `dma2d_addr_gen`

## Requirements
- R1: While reset is high, and in the first cycle after it, req_valid and done are 0 and cur_addr is 0.
- R2: A start_wr pulse with a nonzero row length raises req_valid in the next cycle. In that cycle req_addr and cur_addr both equal start_addr.
- R3: Within a row, each accepted request (req_valid and req_ready high at a clock edge) advances req_addr and cur_addr by req_beats words.
- R4: After the last unit of a row is accepted, the next request address is the start of the previous row plus the stride.
- R5: The row-count input is the number of rows minus one. A value of 0 produces exactly one row.
- R6: With cfg_burst = 1, req_beats is the smaller of 4 and the words left in the row. With cfg_burst = 0, req_beats is 1.
- R7: Row length, row count, stride, direction and burst mode are captured on start_wr. Changing these inputs later has no effect on the running walk. req_dir (1 = peripheral to memory, 0 = memory to peripheral) holds the captured direction.
- R8: done is high for exactly one cycle. That cycle immediately follows the acceptance of the final unit. During it req_valid is 0 and cur_addr equals the last row start plus the row length.
- R9: While req_valid is high and req_ready is low, req_addr and req_beats hold their values.
- R10: stop has priority over all other inputs. In the next cycle req_valid is 0, no done pulse appears, and cur_addr keeps its value.
- R11: A start_wr with a row length of 0 issues no request and gives a done pulse in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_row_len | input | LEN_W | Words per row |
| cfg_row_cnt | input | LEN_W | Rows minus one |
| cfg_stride | input | ADDR_W | Row-start to row-start distance in words |
| cfg_dir | input | 1 | 1 = peripheral to memory, 0 = memory to peripheral |
| cfg_burst | input | 1 | 1 = four-word bursts, 0 = single words |
| start_wr | input | 1 | Start-address write strobe that launches the walk |
| start_addr | input | ADDR_W | Start word address |
| stop | input | 1 | Abort the walk |
| req_valid | output | 1 | Request present |
| req_ready | input | 1 | Request accepted |
| req_addr | output | ADDR_W | Word address of the request |
| req_beats | output | BEAT_W | Words in this request |
| req_dir | output | 1 | Captured direction |
| cur_addr | output | ADDR_W | Next word still to move |
| done | output | 1 | One-cycle completion pulse |

## Verification
A wrong row counter or row-base register shows up in the first request after a row boundary. That request carries an address that is not the previous row start plus the stride, or the done pulse comes early or late by a whole row. A wrong remaining-word count inside a row shows up at once in req_beats, or as an extra or missing unit before the jump. An independent model of rows and columns predicts every request, so any such fault is reported within one handshake of its effect.

// File: rtl/dma2d_pkg.sv
package dma2d_pkg;
  typedef enum logic [0:0] {
    WALK_IDLE = 1'b0,
    WALK_RUN  = 1'b1
  } walk_state_t;
endpackage

// File: rtl/dma2d_cfg_hold.sv
module dma2d_cfg_hold #(
  parameter int ADDR_W = 30,
  parameter int LEN_W  = 12
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic [LEN_W-1:0]  row_len_in,
  input  logic [ADDR_W-1:0] stride_in,
  input  logic              dir_in,
  input  logic              burst_in,
  output logic [LEN_W-1:0]  row_len_q,
  output logic [ADDR_W-1:0] stride_q,
  output logic              dir_q,
  output logic              burst_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      row_len_q <= '0;
      stride_q  <= '0;
      dir_q     <= 1'b0;
      burst_q   <= 1'b0;
    end else if (load) begin
      row_len_q <= row_len_in;
      stride_q  <= stride_in;
      dir_q     <= dir_in;
      burst_q   <= burst_in;
    end
  end
endmodule

// File: rtl/dma2d_row_ctr.sv
module dma2d_row_ctr #(
  parameter int LEN_W       = 12,
  parameter int BURST_WORDS = 4,
  localparam int BEAT_W     = $clog2(BURST_WORDS + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic [LEN_W-1:0]  load_len,
  input  logic              step,
  input  logic              burst,
  output logic [BEAT_W-1:0] beats,
  output logic              row_last
);
  localparam logic [LEN_W-1:0] BURST_L = LEN_W'(BURST_WORDS);

  logic [LEN_W-1:0] words_left;

  generate
    if (BURST_WORDS > 1) begin : g_burst
      always_comb begin
        if (!burst)
          beats = BEAT_W'(1);
        else if (words_left < BURST_L)
          beats = BEAT_W'(words_left);
        else
          beats = BEAT_W'(BURST_WORDS);
      end
    end else begin : g_single
      always_comb beats = BEAT_W'(1);
    end
  endgenerate

  assign row_last = (words_left <= LEN_W'(beats));

  always_ff @(posedge clk) begin
    if (rst)
      words_left <= '0;
    else if (load)
      words_left <= load_len;
    else if (step)
      words_left <= words_left - LEN_W'(beats);
  end
endmodule

// File: rtl/dma2d_frame_seq.sv
module dma2d_frame_seq
  import dma2d_pkg::*;
#(
  parameter int ADDR_W = 30,
  parameter int LEN_W  = 12,
  parameter int BEAT_W = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [ADDR_W-1:0] start_addr,
  input  logic [LEN_W-1:0]  row_cnt_in,
  input  logic              len_zero,
  input  logic              stop,
  input  logic              ready,
  input  logic              row_last,
  input  logic [BEAT_W-1:0] beats,
  input  logic [ADDR_W-1:0] stride,
  output logic              valid,
  output logic [ADDR_W-1:0] cur_addr,
  output logic              done,
  output logic              row_load,
  output logic              step
);
  walk_state_t      state;
  logic [ADDR_W-1:0] row_base;
  logic [LEN_W-1:0]  rows_left;
  logic              fire;
  logic [ADDR_W-1:0] next_base;

  assign valid     = (state == WALK_RUN);
  assign fire      = valid && ready && !stop && !start;
  assign step      = fire;
  assign row_load  = fire && row_last && (rows_left != '0);
  assign next_base = row_base + stride;

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= WALK_IDLE;
      row_base  <= '0;
      cur_addr  <= '0;
      rows_left <= '0;
      done      <= 1'b0;
    end else begin
      done <= 1'b0;
      if (stop) begin
        state <= WALK_IDLE;
      end else if (start) begin
        cur_addr  <= start_addr;
        row_base  <= start_addr;
        rows_left <= row_cnt_in;
        if (len_zero) begin
          state <= WALK_IDLE;
          done  <= 1'b1;
        end else begin
          state <= WALK_RUN;
        end
      end else if (fire) begin
        if (row_last) begin
          if (rows_left == '0) begin
            state    <= WALK_IDLE;
            done     <= 1'b1;
            cur_addr <= cur_addr + ADDR_W'(beats);
          end else begin
            row_base  <= next_base;
            cur_addr  <= next_base;
            rows_left <= rows_left - 1'b1;
          end
        end else begin
          cur_addr <= cur_addr + ADDR_W'(beats);
        end
      end
    end
  end
endmodule

// File: rtl/dma2d_addr_gen.sv
module dma2d_addr_gen #(
  parameter int ADDR_W      = 30,
  parameter int LEN_W       = 12,
  parameter int BURST_WORDS = 4,
  localparam int BEAT_W     = $clog2(BURST_WORDS + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [LEN_W-1:0]  cfg_row_len,
  input  logic [LEN_W-1:0]  cfg_row_cnt,
  input  logic [ADDR_W-1:0] cfg_stride,
  input  logic              cfg_dir,
  input  logic              cfg_burst,
  input  logic              start_wr,
  input  logic [ADDR_W-1:0] start_addr,
  input  logic              stop,
  output logic              req_valid,
  input  logic              req_ready,
  output logic [ADDR_W-1:0] req_addr,
  output logic [BEAT_W-1:0] req_beats,
  output logic              req_dir,
  output logic [ADDR_W-1:0] cur_addr,
  output logic              done
);
  logic              launch;
  logic [LEN_W-1:0]  len_q;
  logic [ADDR_W-1:0] stride_q;
  logic              dir_q;
  logic              burst_q;
  logic              row_load;
  logic              step;
  logic              row_last;
  logic [BEAT_W-1:0] beats;
  logic              ctr_load;
  logic [LEN_W-1:0]  ctr_len;
  logic [ADDR_W-1:0] walk_addr;

  assign launch   = start_wr && !stop;
  assign ctr_load = launch || row_load;
  assign ctr_len  = launch ? cfg_row_len : len_q;

  dma2d_cfg_hold #(.ADDR_W(ADDR_W), .LEN_W(LEN_W)) u_cfg (
    .clk(clk), .rst(rst), .load(launch),
    .row_len_in(cfg_row_len), .stride_in(cfg_stride),
    .dir_in(cfg_dir), .burst_in(cfg_burst),
    .row_len_q(len_q), .stride_q(stride_q),
    .dir_q(dir_q), .burst_q(burst_q)
  );

  dma2d_row_ctr #(.LEN_W(LEN_W), .BURST_WORDS(BURST_WORDS)) u_row (
    .clk(clk), .rst(rst), .load(ctr_load), .load_len(ctr_len),
    .step(step), .burst(launch ? cfg_burst : burst_q),
    .beats(beats), .row_last(row_last)
  );

  dma2d_frame_seq #(.ADDR_W(ADDR_W), .LEN_W(LEN_W), .BEAT_W(BEAT_W)) u_seq (
    .clk(clk), .rst(rst), .start(start_wr), .start_addr(start_addr),
    .row_cnt_in(cfg_row_cnt), .len_zero(cfg_row_len == '0),
    .stop(stop), .ready(req_ready), .row_last(row_last), .beats(beats),
    .stride(stride_q), .valid(req_valid), .cur_addr(walk_addr),
    .done(done), .row_load(row_load), .step(step)
  );

  assign req_addr  = walk_addr;
  assign cur_addr  = walk_addr;
  assign req_beats = beats;
  assign req_dir   = dir_q;
endmodule

// File: rtl/dma2d_addr_gen_chk.sv
module dma2d_addr_gen_chk #(
  parameter int ADDR_W      = 30,
  parameter int LEN_W       = 12,
  parameter int BURST_WORDS = 4,
  localparam int BEAT_W     = $clog2(BURST_WORDS + 1)
) (
  input logic              clk,
  input logic              rst,
  input logic [LEN_W-1:0]  cfg_row_len,
  input logic              start_wr,
  input logic [ADDR_W-1:0] start_addr,
  input logic              stop,
  input logic              req_valid,
  input logic              req_ready,
  input logic [ADDR_W-1:0] req_addr,
  input logic [BEAT_W-1:0] req_beats,
  input logic              done
);
  a_r8_done_single: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);
  a_r8_done_quiet: assert property (@(posedge clk) disable iff (rst)
    done |-> !req_valid);
  a_r10_stop_idle: assert property (@(posedge clk) disable iff (rst)
    stop |=> (!req_valid && !done));
  a_r9_hold: assert property (@(posedge clk) disable iff (rst)
    (req_valid && !req_ready && !stop && !start_wr) |=>
      (req_valid && $stable(req_addr) && $stable(req_beats)));
  a_r6_beats_range: assert property (@(posedge clk) disable iff (rst)
    req_valid |-> (req_beats >= BEAT_W'(1) && req_beats <= BEAT_W'(BURST_WORDS)));
  a_r2_launch: assert property (@(posedge clk) disable iff (rst)
    (start_wr && !stop && cfg_row_len != '0) |=>
      (req_valid && req_addr == $past(start_addr)));
  a_r11_empty_row: assert property (@(posedge clk) disable iff (rst)
    (start_wr && !stop && cfg_row_len == '0) |=> (done && !req_valid));
endmodule

bind dma2d_addr_gen dma2d_addr_gen_chk #(
  .ADDR_W(ADDR_W), .LEN_W(LEN_W), .BURST_WORDS(BURST_WORDS)
) u_chk (
  .clk(clk), .rst(rst), .cfg_row_len(cfg_row_len), .start_wr(start_wr),
  .start_addr(start_addr), .stop(stop), .req_valid(req_valid),
  .req_ready(req_ready), .req_addr(req_addr), .req_beats(req_beats),
  .done(done)
);

// File: tb/dma2d_addr_gen_bench.sv
module dma2d_addr_gen_bench;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 30;
  localparam int LW = 12;
  localparam int BW = 3;

  typedef struct packed {
    logic [29:0] sa;
    logic [11:0] len;
    logic [11:0] cnt;
    logic [29:0] stride;
    logic        burst;
    logic        dir;
    logic        stall;
  } vec_t;

  localparam vec_t VECS [6] = '{
    '{30'h64,   12'd3,  12'd0, 30'd3,  1'b0, 1'b0, 1'b0},
    '{30'h200,  12'd4,  12'd2, 30'd10, 1'b0, 1'b1, 1'b0},
    '{30'h1000, 12'd10, 12'd1, 30'd16, 1'b1, 1'b0, 1'b0},
    '{30'h50,   12'd1,  12'd3, 30'd1,  1'b1, 1'b1, 1'b1},
    '{30'h800,  12'd8,  12'd1, 30'd8,  1'b1, 1'b0, 1'b1},
    '{30'h40,   12'd5,  12'd2, 30'd7,  1'b0, 1'b1, 1'b1}
  };

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [LW-1:0] cfg_row_len = '0;
  logic [LW-1:0] cfg_row_cnt = '0;
  logic [AW-1:0] cfg_stride = '0;
  logic          cfg_dir = 1'b0;
  logic          cfg_burst = 1'b0;
  logic          start_wr = 1'b0;
  logic [AW-1:0] start_addr = '0;
  logic          stop = 1'b0;
  logic          req_ready = 1'b0;
  logic          req_valid;
  logic [AW-1:0] req_addr;
  logic [BW-1:0] req_beats;
  logic          req_dir;
  logic [AW-1:0] cur_addr;
  logic          done;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dma2d_addr_gen u_dma2d_addr_gen (
    .clk(clk), .rst(rst), .cfg_row_len(cfg_row_len), .cfg_row_cnt(cfg_row_cnt),
    .cfg_stride(cfg_stride), .cfg_dir(cfg_dir), .cfg_burst(cfg_burst),
    .start_wr(start_wr), .start_addr(start_addr), .stop(stop),
    .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
    .req_beats(req_beats), .req_dir(req_dir), .cur_addr(cur_addr), .done(done)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000) begin
      errors++;
      $display("FAIL watchdog actual=%0d expected=<20000", cycles);
      $display("Result: errors=%0d of %0d checks", errors, checks + 1);
      $finish;
    end
  end

  task automatic launch(input logic [AW-1:0] sa, input logic [LW-1:0] len,
                        input logic [LW-1:0] cnt, input logic [AW-1:0] stride,
                        input logic burst, input logic dir);
    @(negedge clk);
    cfg_row_len = len; cfg_row_cnt = cnt; cfg_stride = stride;
    cfg_burst = burst; cfg_dir = dir; start_addr = sa; start_wr = 1'b1;
    @(negedge clk);
    start_wr = 1'b0;
    // R7: scramble the configuration inputs after launch
    cfg_row_len = len + 12'd3; cfg_row_cnt = cnt + 12'd2;
    cfg_stride = stride + 30'd5; cfg_burst = ~burst; cfg_dir = ~dir;
  endtask

  task automatic run_vec(input vec_t v);
    logic [AW-1:0] base;
    int c;
    int b;
    launch(v.sa, v.len, v.cnt, v.stride, v.burst, v.dir);
    base = v.sa;
    for (int r = 0; r <= int'(v.cnt); r++) begin
      base = v.sa + AW'(r) * v.stride;   // R4 / R5 row start
      c = 0;
      while (c < int'(v.len)) begin
        b = v.burst ? ((int'(v.len) - c) < 4 ? int'(v.len) - c : 4) : 1;
        chk("R2 req_valid", 32'(req_valid), 32'd1);
        chk("R3 R4 req_addr", 32'(req_addr), 32'(base + AW'(c)));
        chk("R3 cur_addr", 32'(cur_addr), 32'(base + AW'(c)));
        chk("R6 req_beats", 32'(req_beats), 32'(b));
        chk("R7 req_dir", 32'(req_dir), 32'(v.dir));
        if (v.stall) begin
          req_ready = 1'b0;
          @(negedge clk);
          chk("R9 hold addr", 32'(req_addr), 32'(base + AW'(c)));
          chk("R9 hold beats", 32'(req_beats), 32'(b));
        end
        req_ready = 1'b1;
        @(negedge clk);
        req_ready = 1'b0;
        c += b;
        if (!(r == int'(v.cnt) && c >= int'(v.len)))
          chk("R8 no early done", 32'(done), 32'd0);
      end
    end
    chk("R8 done", 32'(done), 32'd1);
    chk("R8 valid low", 32'(req_valid), 32'd0);
    chk("R8 cur_addr end", 32'(cur_addr), 32'(base + AW'(v.len)));
    @(negedge clk);
    chk("R8 done width", 32'(done), 32'd0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 valid in reset", 32'(req_valid), 32'd0);
    chk("R1 done in reset", 32'(done), 32'd0);
    chk("R1 cur_addr in reset", 32'(cur_addr), 32'd0);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 valid after reset", 32'(req_valid), 32'd0);
    chk("R1 cur_addr after reset", 32'(cur_addr), 32'd0);

    for (int i = 0; i < 6; i++) run_vec(VECS[i]);

    // R11: empty row launches nothing
    launch(30'h123, 12'd0, 12'd2, 30'd4, 1'b0, 1'b0);
    chk("R11 done", 32'(done), 32'd1);
    chk("R11 no request", 32'(req_valid), 32'd0);
    @(negedge clk);
    chk("R11 done width", 32'(done), 32'd0);
    chk("R11 still idle", 32'(req_valid), 32'd0);

    // R10: abort after two words
    launch(30'h700, 12'd8, 12'd2, 30'd20, 1'b0, 1'b1);
    req_ready = 1'b1;
    repeat (2) @(negedge clk);
    req_ready = 1'b0;
    chk("R10 pre-stop addr", 32'(cur_addr), 32'h702);
    stop = 1'b1;
    @(negedge clk);
    stop = 1'b0;
    chk("R10 valid low", 32'(req_valid), 32'd0);
    chk("R10 no done", 32'(done), 32'd0);
    chk("R10 cur_addr held", 32'(cur_addr), 32'h702);
    req_ready = 1'b1;
    repeat (3) @(negedge clk);
    req_ready = 1'b0;
    chk("R10 stays idle", 32'(req_valid), 32'd0);
    chk("R10 stays no done", 32'(done), 32'd0);
    chk("R10 cur_addr still held", 32'(cur_addr), 32'h702);

    // R2: restart after an abort
    run_vec('{30'h900, 12'd2, 12'd1, 30'd3, 1'b1, 1'b1, 1'b0});

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule